// File: doc/BRIEF.md
# Configurable Interrupt Controller

This block gathers a vector of interrupt source lines and merges them into two processor request outputs: a normal interrupt request and a fast interrupt request. Each source can be configured on its own as level-sensitive or edge-triggered, and as active-high/rising or active-low/falling. Each source also has an enable mask bit and a routing bit that chooses which of the two outputs it drives.

Edge events are captured in a pending latch that holds until software clears it. Software clears a pending edge by writing a 1 to that bit of the raw view. Level sources follow their synchronized input directly. Software reads the raw view and the masked view over a plain word-addressed register port that has a write enable, write data and combinational read data.

A secondary instance can feed its outputs into source lines of a primary instance, so controllers can be cascaded. Every source line passes through a synchronizer, so it may be asynchronous to the clock.

Top module: `cfg_intc`

## Requirements
- R1: After reset, the enable, polarity, trigger-type and route registers read zero, so every source is disabled, active-low and level-sensitive. Both `irq_o` and `fiq_o` are low.
- R2: The register word indices are: 0 enable (1 = enabled), 1 raw pending, 2 masked pending (read-only), 3 polarity, 4 trigger type, 5 route. The bit position equals the source number. A read of any other index returns zero.
- R3: For a source whose type bit is 0 (level), the raw bit is 1 while the synchronized input equals its polarity bit (1 = high active, 0 = low active). The raw bit drops when the input leaves that level. It follows the input within four clock cycles.
- R4: For a source whose type bit is 1 (edge), the raw bit sets on a rising input transition when polarity is 1, or on a falling transition when polarity is 0. It then stays set after the input returns to its previous level.
- R5: Writing 1 to a raw bit of an edge source clears it. Writing 0 leaves it unchanged. For a level source, writing 1 has no lasting effect on the raw bit.
- R6: If an acknowledge write and a new qualifying edge fall in the same cycle, the raw bit stays set.
- R7: The masked pending view equals raw AND enable. A disabled source never drives either output.
- R8: `irq_o` is the OR of the masked pending bits whose route bit is 0. `fiq_o` is the OR of the masked pending bits whose route bit is 1.
- R9: Writes to the masked pending index change no register.
- R10: Several sources can be pending together, and all of their bits appear at once in the raw and masked views.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source lines, may be asynchronous |
| addr_i | input | AW | Register word index |
| wr_en_i | input | 1 | Write strobe for the indexed register |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data for the indexed register (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench uses the default parameters: 32 sources, a two-stage synchronizer and a three-bit word index. With these values every mapped index is reachable, and so are two unmapped ones. The two synchronizer stages fix the cycle in which a new edge becomes visible. That fixed cycle lets the bench place an acknowledge write exactly on the cycle of a fresh edge. The bench drives high and low bit positions in one step, and so checks that several pending bits appear together.

// File: rtl/cfg_intc.sv
module cfg_intc #(
  parameter int NSRC        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [AW-1:0] IX_EN   = AW'(0);
  localparam logic [AW-1:0] IX_RAW  = AW'(1);
  localparam logic [AW-1:0] IX_STAT = AW'(2);
  localparam logic [AW-1:0] IX_POL  = AW'(3);
  localparam logic [AW-1:0] IX_TYP  = AW'(4);
  localparam logic [AW-1:0] IX_RTE  = AW'(5);

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] prev_q, edge_q;
  logic [NSRC-1:0] en_q, pol_q, typ_q, rte_q;
  logic [NSRC-1:0] src_s, lvl_hit, edge_ev, ack_v, raw_v, stat_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign src_s   = sync_q[SYNC_STAGES-1];
  assign lvl_hit = ~(src_s ^ pol_q);
  assign edge_ev = (src_s & ~prev_q & pol_q) | (~src_s & prev_q & ~pol_q);
  assign ack_v   = (wr_en_i && addr_i == IX_RAW) ? wdata_i : '0;
  assign raw_v   = (typ_q & edge_q) | (~typ_q & lvl_hit);
  assign stat_v  = raw_v & en_q;
  assign irq_o   = |(stat_v & ~rte_q);
  assign fiq_o   = |(stat_v & rte_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      typ_q  <= '0;
      rte_q  <= '0;
    end else begin
      edge_q <= typ_q & (edge_ev | (edge_q & ~ack_v));
      if (wr_en_i) begin
        case (addr_i)
          IX_EN:   en_q  <= wdata_i;
          IX_POL:  pol_q <= wdata_i;
          IX_TYP:  typ_q <= wdata_i;
          IX_RTE:  rte_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      IX_EN:   rdata_o = en_q;
      IX_RAW:  rdata_o = raw_v;
      IX_STAT: rdata_o = stat_v;
      IX_POL:  rdata_o = pol_q;
      IX_TYP:  rdata_o = typ_q;
      IX_RTE:  rdata_o = rte_q;
      default: rdata_o = '0;
    endcase
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((en_q & ~rte_q) != '0)); // R8
  AST_FIQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((en_q & rte_q) != '0)); // R8
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_q & typ_q & ~ack_v) & typ_q & ~edge_q) == '0)); // R4
  AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == IX_STAT) |=> ($stable(en_q) && $stable(pol_q) && $stable(typ_q) && $stable(rte_q))); // R9
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(typ_q)) == '0)); // R3
endmodule

// File: tb/cfg_intc_tb_top.sv
module cfg_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfg_intc dut_i (.clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 enable", d, 32'h0);
    rd(3'd3, d); chk("R1 polarity", d, 32'h0);
    rd(3'd4, d); chk("R1 type", d, 32'h0);
    rd(3'd5, d); chk("R1 route", d, 32'h0);
    chk("R1 outputs", {30'h0, irq_o, fiq_o}, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(3'd3, 32'hA5A5_0000); rd(3'd3, d); chk("R2 polarity rw", d, 32'hA5A5_0000);
    rd(3'd6, d); chk("R2 unmapped 6", d, 32'h0);
    rd(3'd7, d); chk("R2 unmapped 7", d, 32'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(3'd3, 32'h0000_0001);
    @(negedge clk); src_i[0] = 1'b1; idle(4);
    rd(3'd1, d); chk("R3 level high active", d & 32'h3, 32'h3);
    @(negedge clk); src_i[1] = 1'b1; idle(4);
    rd(3'd1, d); chk("R3 level low active drops", d & 32'h3, 32'h1);
    wr(3'd1, 32'h1); idle(1);
    rd(3'd1, d); chk("R5 level ack no effect", d & 32'h1, 32'h1);
    @(negedge clk); src_i[0] = 1'b0; src_i[1] = 1'b0; idle(4);
    rd(3'd1, d); chk("R3 level follows input", d & 32'h3, 32'h2);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    @(negedge clk); src_i[5] = 1'b1; idle(4);
    wr(3'd3, 32'h0000_0009);
    wr(3'd4, 32'h0000_0028);
    wr(3'd1, 32'h0000_0028); idle(1);
    rd(3'd1, d); chk("R4 no stale edge", d & 32'h28, 32'h0);
    @(negedge clk); src_i[3] = 1'b1; idle(4);
    @(negedge clk); src_i[3] = 1'b0; idle(4);
    rd(3'd1, d); chk("R4 rising latched and held", d & 32'h28, 32'h08);
    @(negedge clk); src_i[5] = 1'b0; idle(4);
    @(negedge clk); src_i[5] = 1'b1; idle(4);
    rd(3'd1, d); chk("R4 falling latched and held", d & 32'h28, 32'h28);
    wr(3'd1, 32'h0); idle(1);
    rd(3'd1, d); chk("R5 write zero keeps", d & 32'h28, 32'h28);
    wr(3'd1, 32'h20); idle(1);
    rd(3'd1, d); chk("R5 ack clears one", d & 32'h28, 32'h08);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    @(negedge clk); src_i[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(3'd1, 32'h08); idle(1);
    rd(3'd1, d); chk("R6 edge beats ack", d & 32'h08, 32'h08);
    wr(3'd1, 32'h08); idle(1);
    rd(3'd1, d); chk("R5 ack clears edge", d & 32'h08, 32'h0);
    @(negedge clk); src_i[3] = 1'b0; idle(4);
    @(negedge clk); src_i[3] = 1'b1; idle(4);
  endtask

  task automatic t_routing;
    logic [31:0] d;
    chk("R7 disabled quiet", {30'h0, irq_o, fiq_o}, 32'h0);
    rd(3'd2, d); chk("R7 status masked off", d, 32'h0);
    wr(3'd0, 32'h08); idle(1);
    rd(3'd2, d); chk("R7 status raw and enable", d, 32'h08);
    chk("R8 irq route", {30'h0, irq_o, fiq_o}, 32'h2);
    wr(3'd5, 32'h08); idle(1);
    chk("R8 fiq route", {30'h0, irq_o, fiq_o}, 32'h1);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R9 enable unchanged", d, 32'h08);
    rd(3'd4, d); chk("R9 type unchanged", d, 32'h28);
    rd(3'd2, d); chk("R9 status unchanged", d, 32'h08);
  endtask

  task automatic t_multi;
    logic [31:0] d;
    wr(3'd4, 32'h8000_0028);
    wr(3'd3, 32'h8000_0009);
    wr(3'd0, 32'h8000_0009);
    @(negedge clk); src_i[0] = 1'b1; src_i[31] = 1'b1; idle(4);
    rd(3'd1, d); chk("R10 raw multi", d & 32'h8000_0009, 32'h8000_0009);
    rd(3'd2, d); chk("R10 status multi", d, 32'h8000_0009);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_regmap;
    t_level;
    t_edge;
    t_collision;
    t_routing;
    t_status_ro;
    t_multi;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule